// File: doc/BRIEF.md
# Frame-Synchronous Coefficient Register Bank

This block keeps the run-time programmable coefficients of a two-dimensional FIR filter. Software writes each unique coefficient over a small memory-mapped write port into a pending bank. The filter datapath never sees the pending bank. It reads a separate active bank, presented as one flat vector. The number of slots, `N_COEF`, is the count of unique values that remain after any kernel symmetry. Values arrive already in the filter's fixed-point format and are stored bit for bit, with no rounding or conversion.

A write of any value to the commit address arms an update. The next single-cycle frame-start pulse copies every pending slot into the active bank on one clock edge and clears the armed state. The active coefficients therefore change only between frames, and at most once per frame. Pending slots that software writes between the commit and the frame start are part of that copy.

A combinational read port returns the pending slots. The commit address reads back a status bit that shows whether an update is still armed.

Top module: `coef_frame_bank`

## Requirements
- R1: A write to address 7+k, for 0 <= k < N_COEF, stores `wr_data_i` in pending slot k. It does not change the active bank.
- R2: A write to address 6 arms an update, whatever its data. The pending slots keep their values.
- R3: On a clock edge where `frame_start_i` is high and an update is armed, all N_COEF pending values are copied into the active bank together, visible on the next cycle, and the armed state clears.
- R4: The active bank changes on no other edge. A frame start with nothing armed leaves it unchanged, so the active set changes at most once per frame.
- R5: Pending-slot writes made after a commit and before the frame start are included in the copy.
- R6: If a pending-slot write and a frame start with an armed update fall on the same edge, the copy takes the slot's previous value. The new value stays pending until a later commit.
- R7: If a commit write and a frame start fall on the same edge, any update that was already armed is applied on that edge, and the update stays armed afterwards.
- R8: Writes to addresses 0 to 5 and above N_COEF+6 change neither bank nor the armed state.
- R9: After reset, every pending and active slot is zero and no update is armed.
- R10: Reading address 7+k returns pending slot k. Reading address 6 returns the armed flag in bit 0 with zeros above it. Every other address reads zero.
- R11: Active slot k sits at bits [k*COEF_W +: COEF_W] of `coef_active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | COEF_W | Write data (coefficient value) |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | COEF_W | Combinational read data |
| frame_start_i | input | 1 | Single-cycle frame boundary pulse |
| coef_active_o | output | N_COEF*COEF_W | Active coefficient set, slot 0 in the low bits |

## Verification
Two pairs of events can share a clock edge. The first pair is a frame-start copy and a software write to a pending slot. The bench places both in one drive cycle and checks two things: the active output carries the slot's old value, and a readback shows the new value still pending. The second pair is a commit write and a frame start. The bench drives them together after an earlier commit, then checks that the copy took place and that the status bit reads armed. A further frame pulse must then apply the newer pending values.

// File: rtl/coef_bank_pkg.sv
// Package: address map constants shared by the coefficient bank modules.
// Assumes the address bus is wide enough to hold SLOT_BASE + N_COEF - 1.
package coef_bank_pkg;
    localparam int COMMIT_ADDR = 6;   // write arms update, read gives status
    localparam int SLOT_BASE   = 7;   // address of coefficient slot 0
endpackage

// File: rtl/coef_addr_decode.sv
// Address decoder: turns a write strobe and address into per-slot write
// enables and a commit strobe. Addresses outside the map assert nothing.
// Assumes ADDR_W can represent SLOT_BASE + N_COEF - 1.
module coef_addr_decode #(
    parameter int N_COEF = 9,
    parameter int ADDR_W = 8
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [N_COEF-1:0] slot_we_o,
    output logic              commit_we_o
);
    import coef_bank_pkg::*;

    // Commit strobe: any write to the commit address.
    assign commit_we_o = wr_en_i && (wr_addr_i == ADDR_W'(COMMIT_ADDR));

    // One enable per slot, one comparator each.
    for (genvar k = 0; k < N_COEF; k++) begin : g_slot_dec
        assign slot_we_o[k] = wr_en_i && (wr_addr_i == ADDR_W'(SLOT_BASE + k));
    end
endmodule

// File: rtl/coef_shadow_bank.sv
// Pending bank: one register per unique coefficient, written by software.
// The values are stored unchanged and presented as a flat vector, slot 0 in
// the low bits. Assumes slot_we_i is at most one-hot.
module coef_shadow_bank #(
    parameter int N_COEF = 9,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_COEF-1:0]        slot_we_i,
    input  logic [COEF_W-1:0]        wr_data_i,
    output logic [N_COEF*COEF_W-1:0] shadow_flat_o
);
    for (genvar k = 0; k < N_COEF; k++) begin : g_slot
        logic [COEF_W-1:0] val_q;

        // Hold slot k; clear on reset, load on its write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)            val_q <= '0;
            else if (slot_we_i[k]) val_q <= wr_data_i;
        end

        assign shadow_flat_o[k*COEF_W +: COEF_W] = val_q;
    end
endmodule

// File: rtl/coef_commit_ctrl.sv
// Commit control: keeps the armed flag and issues the copy pulse.
// A frame start copies only when an update is already armed. A commit on the
// same edge as a frame start leaves the flag set for the next frame.
module coef_commit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_we_i,
    input  logic frame_start_i,
    output logic pend_o,
    output logic swap_o
);
    logic pend_q;

    // Copy pulse: frame boundary with an armed update.
    assign swap_o = frame_start_i && pend_q;
    assign pend_o = pend_q;

    // Armed flag: set by commit (which wins), cleared by a copy.
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (commit_we_i) pend_q <= 1'b1;
        else if (swap_o)      pend_q <= 1'b0;
    end
endmodule

// File: rtl/coef_active_bank.sv
// Active bank: the coefficient set the filter uses. It loads the whole
// pending bank in one edge when swap_i is high and otherwise holds.
module coef_active_bank #(
    parameter int N_COEF = 9,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     swap_i,
    input  logic [N_COEF*COEF_W-1:0] shadow_flat_i,
    output logic [N_COEF*COEF_W-1:0] active_flat_o
);
    localparam int FLAT_W = N_COEF * COEF_W;

    logic [FLAT_W-1:0] act_q;

    // Parallel load of every slot on the copy pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (swap_i) act_q <= shadow_flat_i;
    end

    assign active_flat_o = act_q;
endmodule

// File: rtl/coef_frame_bank.sv
// Top: frame-synchronous coefficient register bank for a 2D FIR filter.
// Software writes pending slots at addresses 7..N_COEF+6 and arms an update
// at address 6. The next frame_start_i copies the pending set to
// coef_active_o. Reads are combinational and return pending values, or the
// armed flag at address 6.
// Assumes frame_start_i is a single-cycle pulse in the clk domain.
module coef_frame_bank #(
    parameter int N_COEF = 9,
    parameter int COEF_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [COEF_W-1:0]        wr_data_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [COEF_W-1:0]        rd_data_o,
    input  logic                     frame_start_i,
    output logic [N_COEF*COEF_W-1:0] coef_active_o
);
    import coef_bank_pkg::*;

    localparam int FLAT_W = N_COEF * COEF_W;

    logic [N_COEF-1:0] slot_we;
    logic              commit_we;
    logic              pend;
    logic              swap;
    logic [FLAT_W-1:0] shadow_flat;

    coef_addr_decode #(.N_COEF(N_COEF), .ADDR_W(ADDR_W)) u_dec (
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .slot_we_o   (slot_we),
        .commit_we_o (commit_we)
    );

    coef_shadow_bank #(.N_COEF(N_COEF), .COEF_W(COEF_W)) u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_we_i     (slot_we),
        .wr_data_i     (wr_data_i),
        .shadow_flat_o (shadow_flat)
    );

    coef_commit_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_we_i   (commit_we),
        .frame_start_i (frame_start_i),
        .pend_o        (pend),
        .swap_o        (swap)
    );

    coef_active_bank #(.N_COEF(N_COEF), .COEF_W(COEF_W)) u_active (
        .clk           (clk),
        .rst_n         (rst_n),
        .swap_i        (swap),
        .shadow_flat_i (shadow_flat),
        .active_flat_o (coef_active_o)
    );

    // Readback mux: status at the commit address, pending slots above it.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(COMMIT_ADDR))
            rd_data_o = COEF_W'(pend);
        for (int k = 0; k < N_COEF; k++) begin
            if (rd_addr_i == ADDR_W'(SLOT_BASE + k))
                rd_data_o = shadow_flat[k*COEF_W +: COEF_W];
        end
    end
endmodule

// File: rtl/coef_frame_bank_chk.sv
// Checker: temporal properties of the coefficient bank, bound to the top.
module coef_frame_bank_chk #(
    parameter int N_COEF = 9,
    parameter int COEF_W = 16,
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en_i,
    input logic [ADDR_W-1:0]        wr_addr_i,
    input logic                     frame_start_i,
    input logic                     pend,
    input logic [N_COEF*COEF_W-1:0] shadow_flat,
    input logic [N_COEF*COEF_W-1:0] coef_active_o
);
    localparam int LAST_ADDR = N_COEF + 6;

    logic commit_hit;
    logic out_of_map;
    assign commit_hit = wr_en_i && (wr_addr_i == ADDR_W'(6));
    assign out_of_map = wr_en_i && ((int'(wr_addr_i) < 6) || (int'(wr_addr_i) > LAST_ADDR));

    a_r2_commit_arms: assert property (@(posedge clk) disable iff (!rst_n)
        commit_hit |=> pend);

    a_r2_commit_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        commit_hit |=> $stable(shadow_flat));

    a_r3_copy_whole_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && pend) |=> (coef_active_o == $past(shadow_flat)));

    a_r3_copy_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && pend && !commit_hit) |=> !pend);

    a_r4_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start_i && pend) |=> $stable(coef_active_o));

    a_r8_outside_map_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_map |=> ($stable(shadow_flat) && $stable(pend)));
endmodule

bind coef_frame_bank coef_frame_bank_chk #(
    .N_COEF (N_COEF),
    .COEF_W (COEF_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .frame_start_i (frame_start_i),
    .pend          (pend),
    .shadow_flat   (shadow_flat),
    .coef_active_o (coef_active_o)
);

// File: tb/tb_coef_frame_bank.sv
// Scoreboard bench: driver tasks update a reference model built from the
// requirements and push expected items. A negedge monitor pops and compares.
module tb_coef_frame_bank;
    localparam int N  = 9;
    localparam int W  = 16;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [W-1:0]    wr_data;
    logic [AW-1:0]   rd_addr;
    logic [W-1:0]    rd_data;
    logic            fs;
    logic [N*W-1:0]  act_out;

    always #2 clk = ~clk;  // 250 MHz

    coef_frame_bank #(.N_COEF(N), .COEF_W(W), .ADDR_W(AW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .frame_start_i (fs),
        .coef_active_o (act_out)
    );

    typedef struct {
        bit         is_read;
        int         idx;
        logic [W-1:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 0;

    logic [W-1:0] m_sh  [N];
    logic [W-1:0] m_act [N];
    bit           m_pend;

    // Monitor: compare every queued expectation with the outputs.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [W-1:0] got;
            it = sb_q.pop_front();
            got = it.is_read ? rd_data : act_out[it.idx*W +: W];
            n_checks++;
            if (got !== it.exp) begin
                n_errors++;
                $display("FAIL %s %s idx %0d: got %h expected %h", it.tag,
                         it.is_read ? "read" : "active", it.idx, got, it.exp);
            end
        end
    end

    task automatic model_reset();
        for (int k = 0; k < N; k++) begin m_sh[k] = '0; m_act[k] = '0; end
        m_pend = 0;
    endtask

    // One drive cycle; the model follows the requirements at that edge.
    task automatic step(input bit we, input int addr, input logic [W-1:0] d, input bit f);
        bit commit;
        @(posedge clk); #1;
        wr_en = we; wr_addr = AW'(addr); wr_data = d; fs = f;
        @(posedge clk);
        commit = we && (addr == 6);
        if (f && m_pend)
            for (int k = 0; k < N; k++) m_act[k] = m_sh[k];
        if (we && addr >= 7 && addr <= N + 6) m_sh[addr-7] = d;
        if (commit) m_pend = 1;
        else if (f) m_pend = 0;
        #1;
        wr_en = 0; fs = 0;
    endtask

    task automatic chk_read(input int addr, input logic [W-1:0] exp, input string tag);
        item_t it;
        rd_addr = AW'(addr);
        it.is_read = 1; it.idx = addr; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_active(input string tag);
        for (int k = 0; k < N; k++) begin
            item_t it;
            it.is_read = 0; it.idx = k; it.exp = m_act[k]; it.tag = tag;
            sb_q.push_back(it);
        end
        @(negedge clk); #1;
    endtask

    task automatic chk_shadow(input string tag);
        for (int k = 0; k < N; k++) chk_read(7 + k, m_sh[k], tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        model_reset();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0; fs = 0; rst_n = 0;
        model_reset();
        do_reset();

        // R9: reset state
        chk_active("R9");
        chk_read(6, 16'h0000, "R9");
        chk_shadow("R9");

        // R1: load all slots; active must stay zero
        for (int k = 0; k < N; k++) step(1, 7 + k, W'(16'h1000 + k * 16'h0111), 0);
        chk_shadow("R1");
        chk_active("R1");
        chk_read(20, 16'h0000, "R10");

        // R4: frame start with nothing armed
        step(0, 0, '0, 1);
        chk_active("R4");

        // R2: commit with all-ones data; shadow unchanged, flag set
        step(1, 6, 16'hFFFF, 0);
        chk_read(6, 16'h0001, "R2");
        chk_shadow("R2");
        chk_active("R2");

        // R5: write after commit, then frame start
        step(1, 10, 16'h7777, 0);
        step(0, 0, '0, 1);
        chk_active("R5");
        chk_read(6, 16'h0000, "R3");
        // R11 / R3: explicit flat positions
        chk_active("R11");

        // R4: second frame start without new commit changes nothing
        step(1, 8, 16'hBEEF, 0);
        step(0, 0, '0, 1);
        chk_active("R4");

        // R8: writes outside the map
        for (int a = 0; a < 6; a++) step(1, a, 16'hDEAD, 0);
        step(1, N + 7, 16'hDEAD, 0);
        step(1, 255, 16'hDEAD, 0);
        chk_shadow("R8");
        chk_read(6, 16'h0000, "R8");
        chk_active("R8");

        // R6: slot write on the same edge as an armed frame start
        step(1, 6, 16'h0000, 0);
        step(1, 9, 16'h2222, 1);
        chk_active("R6");
        chk_read(9, 16'h2222, "R6");
        chk_read(6, 16'h0000, "R6");
        step(0, 0, '0, 1);
        chk_active("R6");

        // R7: commit on the same edge as an armed frame start
        step(1, 6, 16'h0000, 0);
        step(1, 6, 16'h1234, 1);
        chk_active("R7");
        chk_read(6, 16'h0001, "R7");
        step(1, 15, 16'h5A5A, 0);
        step(0, 0, '0, 1);
        chk_active("R7");
        chk_read(6, 16'h0000, "R7");

        // R9: reset again clears everything
        do_reset();
        chk_active("R9");
        chk_shadow("R9");
        chk_read(6, 16'h0000, "R9");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule